// File: doc/BRIEF.md
# Per-Bit Configurable Interrupt Cause Controller

This block collects up to 32 interrupt sources into a bank of seven 32-bit words on a simple register bus. Source `n` owns bit `n` of every word. Hardware event pulses and software writes set cause bits. A per-bit clear-style control picks, at run time, how each cause bit is cleared:

- write-one-to-clear, or
- cleared as a side effect of being read.

A mask register hides cause bits from the single level interrupt output. The mask can be written as a whole, or changed bit by bit through separate set and clear words.

Software normally works as follows. It picks a clear style for each source and sets up the mask. On an interrupt it reads the masked view. It then acknowledges either by writing ones back or by relying on the read itself.

Word index map, on a 3-bit word address:

| Index | Word |
|---|---|
| 0 | clear-style control |
| 1 | raw cause |
| 2 | masked cause |
| 3 | cause-set |
| 4 | mask |
| 5 | mask-set |
| 6 | mask-clear |
| 7 | unused |

Top module: `irq_cause_ctrl`

## Requirements
- R1: After reset the control and cause words read 0, the mask word reads all ones, and `irq_out` is low.
- R2: The control word (index 0) is read and written directly. Control bit 0 selects write-one-to-clear for that cause bit; control bit 1 selects clear-on-read.
- R3: A 1 on `hw_event[n]` sets cause bit n in the next cycle. When an event and any clear hit the same bit in one cycle, the bit ends set.
- R4: Each 1 written to the cause-set word (index 3) sets the matching cause bit. Reading index 3 returns 0.
- R5: For a cause bit whose control bit is 0, writing a 1 to the cause word (index 1) or to the masked word (index 2) clears it. For a bit whose control bit is 1, such writes have no effect. Writing 0 never clears a bit.
- R6: Reading the cause word returns the cause value from before the read. The read clears every cause bit whose control bit is 1 and leaves bits whose control bit is 0 unchanged.
- R7: The masked word (index 2) reads as cause AND NOT mask. Reading it clears only those clear-on-read bits that were visible, meaning unmasked and set.
- R8: The mask word (index 4) is read and written directly. A mask bit of 1 hides its source.
- R9: Writing 1s to mask-set (index 5) sets those mask bits, and writing 1s to mask-clear (index 6) clears them. Zero bits leave the mask unchanged, and both words read 0.
- R10: `irq_out` is high exactly when some cause bit is set while its mask bit is 0. It follows the registered state with no extra delay.
- R11: Read data is registered and appears on `reg_rdata` in the cycle after `reg_rd`. It is 0 in cycles after no read. Index 7 reads 0, and writes to index 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Word index |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data |
| hw_event | input | 32 | Per-source event pulses |
| irq_out | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default 32 sources and 3-bit word index. This exercises every bit position up to bit 31, where mixed clear styles coexist inside one word, and the unused index 7. Random control, mask and event patterns mix write-one-to-clear and clear-on-read bits in the same word. Directed cases pit an event against a clear on the same bit and read the masked view with partial masks.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int IDX_W = 3;

    typedef enum logic [IDX_W-1:0] {
        WI_CTRL   = 3'd0,
        WI_CAUSE  = 3'd1,
        WI_MASKED = 3'd2,
        WI_SET    = 3'd3,
        WI_MASK   = 3'd4,
        WI_MSET   = 3'd5,
        WI_MCLR   = 3'd6,
        WI_NONE   = 3'd7
    } word_idx_e;

    typedef struct packed {
        logic wr_ctrl;
        logic wr_cause;
        logic wr_masked;
        logic wr_set;
        logic wr_mask;
        logic wr_mset;
        logic wr_mclr;
        logic rd_cause;
        logic rd_masked;
    } strobe_t;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
(
    input  logic [IDX_W-1:0] addr,
    input  logic             wr,
    input  logic             rd,
    output strobe_t          strb
);
    always_comb begin
        strb           = '0;
        strb.wr_ctrl   = wr && (addr == WI_CTRL);
        strb.wr_cause  = wr && (addr == WI_CAUSE);
        strb.wr_masked = wr && (addr == WI_MASKED);
        strb.wr_set    = wr && (addr == WI_SET);
        strb.wr_mask   = wr && (addr == WI_MASK);
        strb.wr_mset   = wr && (addr == WI_MSET);
        strb.wr_mclr   = wr && (addr == WI_MCLR);
        strb.rd_cause  = rd && (addr == WI_CAUSE);
        strb.rd_masked = rd && (addr == WI_MASKED);
    end
endmodule

// File: rtl/irqc_mask.sv
module irqc_mask
    import irqc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  strobe_t      strb,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask_q
);
    typedef struct packed {
        logic [W-1:0] mask;
    } mstate_t;

    mstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (strb.wr_mask) begin
            st_d.mask = wdata;
        end
        if (strb.wr_mset) begin
            st_d.mask = st_q.mask | wdata;
        end
        if (strb.wr_mclr) begin
            st_d.mask = st_q.mask & ~wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_q = st_q.mask;

    AST_MSET_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        strb.wr_mset |=> ((mask_q & $past(wdata)) == $past(wdata)))
        else $error("mask-set failed"); // R9
    AST_MCLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        strb.wr_mclr |=> ((mask_q & $past(wdata)) == '0))
        else $error("mask-clear failed"); // R9
    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(strb.wr_mask || strb.wr_mset || strb.wr_mclr) |=> $stable(mask_q))
        else $error("mask changed without write"); // R8
endmodule

// File: rtl/irqc_cause.sv
module irqc_cause
    import irqc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  strobe_t      strb,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] hw_event,
    input  logic [W-1:0] mask_q,
    output logic [W-1:0] ctrl_q,
    output logic [W-1:0] cause_q
);
    typedef struct packed {
        logic [W-1:0] ctrl;
        logic [W-1:0] cause;
    } cstate_t;

    cstate_t      st_d, st_q;
    logic [W-1:0] clr_w1c;
    logic [W-1:0] clr_cor;
    logic [W-1:0] set_sw;

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign clr_w1c[b] = (strb.wr_cause || strb.wr_masked) && wdata[b] && !st_q.ctrl[b];
        assign clr_cor[b] = st_q.ctrl[b] &&
                            (strb.rd_cause || (strb.rd_masked && !mask_q[b]));
        assign set_sw[b]  = strb.wr_set && wdata[b];
    end

    always_comb begin
        st_d = st_q;
        if (strb.wr_ctrl) begin
            st_d.ctrl = wdata;
        end
        st_d.cause = (st_q.cause & ~(clr_w1c | clr_cor)) | set_sw | hw_event;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_q  = st_q.ctrl;
    assign cause_q = st_q.cause;

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_event != '0) |=> ((cause_q & $past(hw_event)) == $past(hw_event)))
        else $error("event lost"); // R3
    AST_COR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (strb.rd_cause && hw_event == '0 && !strb.wr_set)
        |=> ((cause_q & $past(ctrl_q)) == '0))
        else $error("clear-on-read left bits"); // R6
    AST_W1C_SPARES_COR: assert property (@(posedge clk) disable iff (!rst_n)
        (strb.wr_cause && !strb.rd_cause && !strb.rd_masked)
        |=> ((cause_q & $past(ctrl_q & cause_q)) == $past(ctrl_q & cause_q)))
        else $error("write cleared a clear-on-read bit"); // R5
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
    import irqc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] reg_addr,
    input  logic             reg_wr,
    input  logic [W-1:0]     reg_wdata,
    input  logic             reg_rd,
    output logic [W-1:0]     reg_rdata,
    input  logic [W-1:0]     hw_event,
    output logic             irq_out
);
    typedef struct packed {
        logic [W-1:0] rdata;
    } rstate_t;

    strobe_t      strb;
    logic [W-1:0] mask_q;
    logic [W-1:0] ctrl_q;
    logic [W-1:0] cause_q;
    logic [W-1:0] masked;
    rstate_t      rs_d, rs_q;

    irqc_decode u_dec (
        .addr (reg_addr),
        .wr   (reg_wr),
        .rd   (reg_rd),
        .strb (strb)
    );

    irqc_mask #(.W(W)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .strb   (strb),
        .wdata  (reg_wdata),
        .mask_q (mask_q)
    );

    irqc_cause #(.W(W)) u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .strb     (strb),
        .wdata    (reg_wdata),
        .hw_event (hw_event),
        .mask_q   (mask_q),
        .ctrl_q   (ctrl_q),
        .cause_q  (cause_q)
    );

    assign masked = cause_q & ~mask_q;

    always_comb begin
        rs_d.rdata = '0;
        if (reg_rd) begin
            case (reg_addr)
                WI_CTRL:   rs_d.rdata = ctrl_q;
                WI_CAUSE:  rs_d.rdata = cause_q;
                WI_MASKED: rs_d.rdata = masked;
                WI_MASK:   rs_d.rdata = mask_q;
                default:   rs_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign reg_rdata = rs_q.rdata;
    assign irq_out   = |masked;

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_q == '0) |-> !irq_out)
        else $error("irq without cause"); // R10
    AST_WO_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && (reg_addr == WI_SET || reg_addr == WI_MSET ||
                    reg_addr == WI_MCLR || reg_addr == WI_NONE)) |=> (reg_rdata == '0))
        else $error("write-only word read nonzero"); // R11
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> (reg_rdata == '0))
        else $error("read data without read"); // R11
endmodule

// File: tb/irq_cause_ctrl_test.sv
`timescale 1ns/1ps
module irq_cause_ctrl_test;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic         reg_wr = 1'b0;
    logic [W-1:0] reg_wdata = '0;
    logic         reg_rd = 1'b0;
    logic [W-1:0] reg_rdata;
    logic [W-1:0] hw_event = '0;
    logic         irq_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [W-1:0] m_ctrl, m_cause, m_mask;

    always #4 clk = ~clk;

    irq_cause_ctrl #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .hw_event(hw_event), .irq_out(irq_out)
    );

    function automatic logic [W-1:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0: return m_ctrl;
            3'd1: return m_cause;
            3'd2: return m_cause & ~m_mask;
            3'd4: return m_mask;
            default: return '0;
        endcase
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // one bus cycle; model updated from requirements, checks sampled after the edge
    task automatic op(input string req, input logic [2:0] a, input bit wr,
                      input logic [W-1:0] wd, input bit rd, input logic [W-1:0] ev);
        logic [W-1:0] exp_rd, clr, nc;
        exp_rd = rd ? exp_read(a) : '0;
        clr = '0;
        if (wr && (a == 3'd1 || a == 3'd2)) clr |= wd & ~m_ctrl;
        if (rd && a == 3'd1) clr |= m_ctrl;
        if (rd && a == 3'd2) clr |= m_ctrl & ~m_mask;
        nc = m_cause & ~clr;
        if (wr && a == 3'd3) nc |= wd;
        nc |= ev;
        if (wr && a == 3'd0) m_ctrl = wd;
        if (wr && a == 3'd4) m_mask = wd;
        if (wr && a == 3'd5) m_mask = m_mask | wd;
        if (wr && a == 3'd6) m_mask = m_mask & ~wd;
        m_cause = nc;
        reg_addr = a; reg_wr = wr; reg_wdata = wd; reg_rd = rd; hw_event = ev;
        @(negedge clk);
        reg_wr = 0; reg_rd = 0; hw_event = '0;
        check(req, reg_rdata, exp_rd);
        check({req, " R10 irq"}, {31'd0, irq_out}, {31'd0, |(m_cause & ~m_mask)});
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a);
        op(req, a, 0, '0, 1, '0);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        if (!done) begin
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_ctrl = '0; m_cause = '0; m_mask = '1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        rd_chk("R1 ctrl", 3'd0);
        rd_chk("R1 cause", 3'd1);
        rd_chk("R1 mask", 3'd4);
        check("R1 irq", {31'd0, irq_out}, 32'd0);
        // R2 control
        op("R2 write", 3'd0, 1, 32'hF0F0_00FF, 0, '0);
        rd_chk("R2 read", 3'd0);
        // R4 set word, reads zero
        op("R4 set", 3'd3, 1, 32'h8000_0101, 0, '0);
        rd_chk("R4 cause", 3'd1);
        op("R4 set", 3'd3, 1, 32'h0000_1000, 0, '0);
        rd_chk("R4 readzero", 3'd3);
        // R8 / R9 mask
        op("R8 mask", 3'd4, 1, 32'h0000_FFFF, 0, '0);
        rd_chk("R8 read", 3'd4);
        op("R9 mset", 3'd5, 1, 32'h0001_0000, 0, '0);
        op("R9 mclr", 3'd6, 1, 32'h0000_0F00, 0, '0);
        rd_chk("R9 mask", 3'd4);
        rd_chk("R9 mset readzero", 3'd5);
        rd_chk("R9 mclr readzero", 3'd6);
        op("R9 zero mset", 3'd5, 1, '0, 0, '0);
        op("R9 zero mclr", 3'd6, 1, '0, 0, '0);
        rd_chk("R9 unchanged", 3'd4);
        // R5 W1C on mixed control
        op("R5 fill", 3'd3, 1, 32'hFFFF_FFFF, 0, '0);
        op("R5 w1c", 3'd1, 1, 32'h0F0F_0F0F, 0, '0);
        rd_chk("R5 masked", 3'd2);
        op("R5 w1c masked", 3'd2, 1, 32'hFFFF_0000, 0, '0);
        op("R5 fill", 3'd3, 1, 32'hFFFF_FFFF, 0, '0);
        // R7 masked read clears only visible clear-on-read bits
        rd_chk("R7 masked", 3'd2);
        rd_chk("R7 after", 3'd1);
        // R6 read clears clear-on-read bits
        op("R6 fill", 3'd3, 1, 32'hFFFF_FFFF, 0, '0);
        rd_chk("R6 cause", 3'd1);
        rd_chk("R6 after", 3'd1);
        // R3 event wins over W1C and COR
        op("R3 ctrl", 3'd0, 1, 32'h0000_0002, 0, '0);
        op("R3 fill", 3'd3, 1, 32'h0000_0003, 0, '0);
        op("R3 w1c vs event", 3'd1, 1, 32'h0000_0001, 0, 32'h0000_0001);
        op("R3 cor vs event", 3'd1, 0, '0, 1, 32'h0000_0002);
        rd_chk("R3 after", 3'd1);
        // R11 unused index
        op("R11 wr7", 3'd7, 1, 32'hDEAD_BEEF, 0, '0);
        rd_chk("R11 rd7", 3'd7);
        rd_chk("R11 ctrl", 3'd0);
        rd_chk("R11 mask", 3'd4);
        // R10 irq with all unmasked
        op("R10 unmask", 3'd6, 1, 32'hFFFF_FFFF, 0, '0);
        op("R10 ev", 3'd7, 0, '0, 0, 32'h4000_0000);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] a;
            bit wr, rd;
            logic [W-1:0] wd, ev;
            a = 3'($urandom_range(0, 7));
            wr = ($urandom_range(0, 2) == 0);
            rd = ($urandom_range(0, 1) == 0);
            wd = $urandom();
            if (a == 3'd4 || a == 3'd5) wd = wd & $urandom();
            ev = ($urandom_range(0, 3) == 0) ? ($urandom() & $urandom() & $urandom()) : '0;
            op("R3 R5 R6 R7 R9 random", a, wr, wd, rd, ev);
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule